// File: doc/BRIEF.md
# Write Unlock Sequencer for a Byte-Wide Nonvolatile Memory

This block sits on the write path of a byte-wide nonvolatile memory and decides what each write strobe means. It samples the chip-select, output-enable and write-enable strobes on the system clock. A strobe counts as a write only when it holds the write condition for a minimum number of cycles. The address is captured at the start of the strobe and the data at its end. Each accepted write then goes out to the downstream load controller as a single-cycle record that carries a classification.

Protection works by software: every byte or page load must begin with a three-write unlock. The unlock bytes are marked as commands, and the load controller drops their data while the addresses stay ordinary storage locations. Writes that follow inside the inter-byte window are payload to store. A write with no valid unlock in front of it is marked as a dummy, so the controller runs its timed cycle but stores nothing. Hardware inhibits sit in front of all of this: a power-on hold after the supply-good input rises, the strobe-level inhibit conditions, and a glitch filter on strobe width.

Top module: `wp_cmd_seq`

## Requirements
- R1: While `rst` is high and in the cycle after it, `wr_valid` is 0, and `wr_class`, `wr_addr` and `wr_data` are all zero. The sequencer starts at its first unlock step.
- R2: A write condition exists only in a cycle where `ce_n`=0, `we_n`=0 and `oe_n`=1. A strobe held with `oe_n` low, or with `ce_n` high, produces no record.
- R3: A write condition held for fewer than `MIN_PULSE` consecutive clock edges produces no record. One held for `MIN_PULSE` or more edges produces exactly one single-cycle `wr_valid` pulse. The pulse is visible two rising edges after the first edge that samples the strobe released.
- R4: No record is produced unless `pwr_ok` has been high for at least `PWR_DELAY` consecutive cycles. Any low cycle of `pwr_ok` restarts the hold.
- R5: The unlock is three writes in this order: address 0x1555 with data 0xAA, then 0x0AAA with 0x55, then 0x1555 with 0xA0. Each of these writes is reported with `wr_class` = 1 (command).
- R6: Once the unlock is complete, each following write is reported with `wr_class` = 2 (store), whatever its address and data, as long as no two successive records are more than `BYTE_GAP` cycles apart.
- R7: If more than `BYTE_GAP` cycles pass without a record while an unlock is partly done or a load is open, the sequencer returns to its first step. The next write must start a fresh unlock.
- R8: A write that arrives at the first step and does not match the first unlock write is reported with `wr_class` = 3 (dummy). So is a write that does not match the expected unlock write partway through the sequence. Such a write also resets the sequencer to its first step.
- R9: `wr_addr` carries the address sampled on the first cycle of the strobe, and `wr_data` carries the data sampled on the last cycle of the strobe. When `wr_valid` is 0, `wr_class` and `wr_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_ok | input | 1 | Supply-good flag from the threshold detector |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Memory address bus |
| din | input | DATA_W | Write data bus |
| wr_valid | output | 1 | One-cycle pulse per accepted write |
| wr_class | output | 2 | 1 command, 2 store, 3 dummy, 0 idle |
| wr_addr | output | ADDR_W | Address captured for the write |
| wr_data | output | DATA_W | Data captured for the write |

## Verification
The assertions check on every cycle:
- each record is a single pulse;
- each record is tied to a strobe release three cycles earlier, with `pwr_ok` high at that time;
- a command record carries one of the unlock address and data pairs;
- a store record is never more than `BYTE_GAP` cycles after the record before it;
- the output fields are zero whenever they are idle.

Only the bench's scenarios can show the following:
- the sequence order;
- the reset caused by a mismatch or by a timeout;
- the glitch-width boundary;
- the power-hold restart;
- where in the strobe the address and the data are captured.

The bench covers these with directed cases and with random writes checked against a reference model.

// File: rtl/wp_cmd_seq_pkg.sv
package wp_cmd_seq_pkg;
  typedef enum logic [1:0] {
    WC_NONE  = 2'd0,
    WC_CMD   = 2'd1,
    WC_STORE = 2'd2,
    WC_DUMMY = 2'd3
  } wr_class_e;
endpackage

// File: rtl/wp_power_hold.sv
// Holds off writes until the supply-good flag has stayed high long enough.
module wp_power_hold #(
  parameter int PWR_DELAY = 2500000
) (
  input  logic clk,
  input  logic rst,
  input  logic pwr_ok,
  output logic ready
);
  localparam int PWR_W = $clog2(PWR_DELAY + 1);
  localparam logic [PWR_W-1:0] PWR_LIM = PWR_W'(PWR_DELAY);

  logic [PWR_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !pwr_ok) begin
      cnt   <= '0;
      ready <= 1'b0;
    end else begin
      if (cnt != PWR_LIM) cnt <= cnt + 1'b1;
      ready <= (cnt == PWR_LIM);
    end
  end
endmodule

// File: rtl/wp_strobe_filter.sv
// Qualifies write strobes by level and width, capturing address and data.
module wp_strobe_filter #(
  parameter int ADDR_W    = 13,
  parameter int DATA_W    = 8,
  parameter int MIN_PULSE = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ready,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic              ev_valid,
  output logic [ADDR_W-1:0] ev_addr,
  output logic [DATA_W-1:0] ev_data
);
  localparam int CNT_W = $clog2(MIN_PULSE + 1);
  localparam logic [CNT_W-1:0] CNT_LIM = CNT_W'(MIN_PULSE);

  logic              act;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] a_lat;
  logic [DATA_W-1:0] d_lat;

  // write condition: selected, write strobe low, outputs disabled, power held
  assign act = ~ce_n & ~we_n & oe_n & ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      a_lat    <= '0;
      d_lat    <= '0;
      ev_valid <= 1'b0;
      ev_addr  <= '0;
      ev_data  <= '0;
    end else begin
      ev_valid <= 1'b0;
      if (act) begin
        if (cnt == '0) a_lat <= addr;
        d_lat <= din;
        if (cnt != CNT_LIM) cnt <= cnt + 1'b1;
      end else begin
        if (cnt == CNT_LIM && ready) begin
          ev_valid <= 1'b1;
          ev_addr  <= a_lat;
          ev_data  <= d_lat;
        end
        cnt <= '0;
      end
    end
  end
endmodule

// File: rtl/wp_unlock_fsm.sv
// Tracks the unlock sequence and the inter-byte window, classifies writes.
module wp_unlock_fsm
  import wp_cmd_seq_pkg::*;
#(
  parameter int ADDR_W    = 13,
  parameter int DATA_W    = 8,
  parameter int CMD_STEPS = 3,
  parameter int BYTE_GAP  = 25000,
  parameter logic [CMD_STEPS-1:0][ADDR_W-1:0] CMD_ADDR = '0,
  parameter logic [CMD_STEPS-1:0][DATA_W-1:0] CMD_DATA = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_valid,
  input  logic [ADDR_W-1:0] ev_addr,
  input  logic [DATA_W-1:0] ev_data,
  output logic              wr_valid,
  output logic [1:0]        wr_class,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  localparam int STEP_W = $clog2(CMD_STEPS + 1);
  localparam int HIT_N  = 1 << STEP_W;
  localparam int GAP_W  = $clog2(BYTE_GAP + 1);
  localparam logic [GAP_W-1:0]  GAP_LIM  = GAP_W'(BYTE_GAP);
  localparam logic [STEP_W-1:0] STEP_OPEN = STEP_W'(CMD_STEPS);

  logic [STEP_W-1:0] step, eff_step, nstep;
  logic [GAP_W-1:0]  gap;
  logic              expired;
  logic [HIT_N-1:0]  hit;
  wr_class_e         cls;

  genvar gi;
  generate
    for (gi = 0; gi < HIT_N; gi++) begin : g_hit
      if (gi < CMD_STEPS) begin : g_real
        assign hit[gi] = (ev_addr == CMD_ADDR[gi]) && (ev_data == CMD_DATA[gi]);
      end else begin : g_pad
        assign hit[gi] = 1'b0;
      end
    end
  endgenerate

  assign expired  = (gap == GAP_LIM);
  assign eff_step = expired ? '0 : step;

  always_comb begin
    if (eff_step == STEP_OPEN) begin
      cls   = WC_STORE;
      nstep = STEP_OPEN;
    end else if (hit[eff_step]) begin
      cls   = WC_CMD;
      nstep = eff_step + 1'b1;
    end else begin
      cls   = WC_DUMMY;
      nstep = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      step     <= '0;
      gap      <= '0;
      wr_valid <= 1'b0;
      wr_class <= WC_NONE;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      wr_valid <= ev_valid;
      wr_class <= ev_valid ? cls : WC_NONE;
      wr_addr  <= ev_valid ? ev_addr : '0;
      wr_data  <= ev_valid ? ev_data : '0;
      if (ev_valid) begin
        step <= nstep;
        gap  <= '0;
      end else if (expired) begin
        step <= '0;
        gap  <= '0;
      end else if (step != '0) begin
        gap <= gap + 1'b1;
      end
    end
  end
endmodule

// File: rtl/wp_cmd_seq.sv
// Top: power hold, strobe qualification, unlock sequencing.
module wp_cmd_seq #(
  parameter int ADDR_W    = 13,
  parameter int DATA_W    = 8,
  parameter int MIN_PULSE = 4,
  parameter int PWR_DELAY = 2500000,
  parameter int BYTE_GAP  = 25000,
  parameter int CMD_STEPS = 3,
  parameter logic [CMD_STEPS-1:0][ADDR_W-1:0] CMD_ADDR =
    {13'h1555, 13'h0AAA, 13'h1555},
  parameter logic [CMD_STEPS-1:0][DATA_W-1:0] CMD_DATA =
    {8'hA0, 8'h55, 8'hAA}
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwr_ok,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic              wr_valid,
  output logic [1:0]        wr_class,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  logic              ready;
  logic              ev_valid;
  logic [ADDR_W-1:0] ev_addr;
  logic [DATA_W-1:0] ev_data;

  wp_power_hold #(.PWR_DELAY(PWR_DELAY)) u_hold (
    .clk(clk), .rst(rst), .pwr_ok(pwr_ok), .ready(ready)
  );

  wp_strobe_filter #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MIN_PULSE(MIN_PULSE)
  ) u_filt (
    .clk(clk), .rst(rst), .ready(ready),
    .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .addr(addr), .din(din),
    .ev_valid(ev_valid), .ev_addr(ev_addr), .ev_data(ev_data)
  );

  wp_unlock_fsm #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMD_STEPS(CMD_STEPS),
    .BYTE_GAP(BYTE_GAP), .CMD_ADDR(CMD_ADDR), .CMD_DATA(CMD_DATA)
  ) u_fsm (
    .clk(clk), .rst(rst),
    .ev_valid(ev_valid), .ev_addr(ev_addr), .ev_data(ev_data),
    .wr_valid(wr_valid), .wr_class(wr_class),
    .wr_addr(wr_addr), .wr_data(wr_data)
  );
endmodule

// File: rtl/wp_cmd_seq_chk.sv
module wp_cmd_seq_chk #(
  parameter int ADDR_W    = 13,
  parameter int DATA_W    = 8,
  parameter int BYTE_GAP  = 25000,
  parameter int CMD_STEPS = 3,
  parameter logic [CMD_STEPS-1:0][ADDR_W-1:0] CMD_ADDR = '0,
  parameter logic [CMD_STEPS-1:0][DATA_W-1:0] CMD_DATA = '0
) (
  input logic              clk,
  input logic              rst,
  input logic              pwr_ok,
  input logic              ce_n,
  input logic              oe_n,
  input logic              we_n,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] din,
  input logic              wr_valid,
  input logic [1:0]        wr_class,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data
);
  localparam int IDLE_W = $clog2(BYTE_GAP + 2);
  localparam logic [IDLE_W-1:0] IDLE_MAX = IDLE_W'(BYTE_GAP + 1);

  logic                 strobe;
  logic [CMD_STEPS-1:0] pair_ok;
  logic [IDLE_W-1:0]    idle_cnt;

  assign strobe = ~ce_n & ~we_n & oe_n;

  genvar gi;
  generate
    for (gi = 0; gi < CMD_STEPS; gi++) begin : g_pair
      assign pair_ok[gi] = (wr_addr == CMD_ADDR[gi]) && (wr_data == CMD_DATA[gi]);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) idle_cnt <= IDLE_MAX;
    else if (wr_valid) idle_cnt <= '0;
    else if (idle_cnt != IDLE_MAX) idle_cnt <= idle_cnt + 1'b1;
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> !wr_valid && wr_class == 2'd0);

  // R3
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    wr_valid |=> !wr_valid);

  // R2
  release_origin_chk: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> $past(strobe, 3) && !$past(strobe, 2));

  // R4
  power_held_chk: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> $past(pwr_ok, 3));

  // R5
  cmd_pair_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_class == 2'd1) |-> (pair_ok != '0));

  // R7
  store_window_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_class == 2'd2) |-> idle_cnt < IDLE_W'(BYTE_GAP));

  // R9
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_valid |-> wr_class == 2'd0 && wr_data == '0);
endmodule

bind wp_cmd_seq wp_cmd_seq_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BYTE_GAP(BYTE_GAP),
  .CMD_STEPS(CMD_STEPS), .CMD_ADDR(CMD_ADDR), .CMD_DATA(CMD_DATA)
) u_chk (
  .clk(clk), .rst(rst), .pwr_ok(pwr_ok), .ce_n(ce_n), .oe_n(oe_n),
  .we_n(we_n), .addr(addr), .din(din), .wr_valid(wr_valid),
  .wr_class(wr_class), .wr_addr(wr_addr), .wr_data(wr_data)
);

// File: tb/wp_cmd_seq_test.sv
module wp_cmd_seq_test;
  localparam int MINP = 3;
  localparam int PDLY = 40;
  localparam int GAP  = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pwr_ok = 1'b0;
  logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [12:0] addr = '0;
  logic [7:0]  din = '0;
  logic        wr_valid;
  logic [1:0]  wr_class;
  logic [12:0] wr_addr;
  logic [7:0]  wr_data;

  int checks = 0;
  int errors = 0;
  int step = 0;   // model: unlock steps done, 3 = load open

  always #2 clk = ~clk;

  wp_cmd_seq #(.MIN_PULSE(MINP), .PWR_DELAY(PDLY), .BYTE_GAP(GAP)) uut (
    .clk(clk), .rst(rst), .pwr_ok(pwr_ok), .ce_n(ce_n), .oe_n(oe_n),
    .we_n(we_n), .addr(addr), .din(din), .wr_valid(wr_valid),
    .wr_class(wr_class), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: act=hung exp=finished");
    finish_run();
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // unlock table from R5
  function automatic logic [12:0] cmd_a(input int i);
    return (i == 1) ? 13'h0AAA : 13'h1555;
  endfunction
  function automatic logic [7:0] cmd_d(input int i);
    return (i == 0) ? 8'hAA : (i == 1) ? 8'h55 : 8'hA0;
  endfunction
  function automatic logic [1:0] model_cls(input int st, input logic [12:0] a, input logic [7:0] d);
    if (st == 3) return 2'd2;
    if (a == cmd_a(st) && d == cmd_d(st)) return 2'd1;
    return 2'd3;
  endfunction
  function automatic int model_next(input int st, input logic [1:0] c);
    if (c == 2'd2) return 3;
    if (c == 2'd1) return st + 1;
    return 0;
  endfunction

  // mode: 0 normal, 1 oe low, 2 ce high, 3 addr/data change mid-strobe
  task automatic do_write(input logic [12:0] a, input logic [7:0] d, input int k,
                          input int mode, input bit exp_ev, input logic [1:0] exp_cls,
                          input string tag);
    int seen = 0;
    int at = 0;
    logic [1:0]  gc = '0;
    logic [12:0] ga = '0;
    logic [7:0]  gd = '0;
    @(negedge clk);
    addr = a;
    din  = (mode == 3) ? ~d : d;
    ce_n = (mode == 2);
    we_n = 1'b0;
    oe_n = (mode != 1);
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      if (mode == 3) begin
        addr = a ^ 13'h1FFF;
        if (i == k - 2) din = d;
      end
    end
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    for (int i = 1; i <= 4; i++) begin
      @(negedge clk);
      if (wr_valid) begin
        seen++; at = i; gc = wr_class; ga = wr_addr; gd = wr_data;
      end else if (i == 1) begin
        check(wr_class == 2'd0 && wr_data == 8'd0, {tag, " R9 idle fields"}, wr_class, 0);
      end
    end
    if (exp_ev) begin
      check(seen == 1 && at == 2, {tag, " R3 one pulse at release+2"}, at, 2);
      check(gc == exp_cls, {tag, " class"}, gc, exp_cls);
      check(ga == a && gd == d, {tag, " R9 addr/data"}, {ga, gd}, {a, d});
    end else begin
      check(seen == 0, {tag, " no record"}, seen, 0);
    end
  endtask

  task automatic wr(input logic [12:0] a, input logic [7:0] d, input string tag);
    logic [1:0] c = model_cls(step, a, d);
    do_write(a, d, MINP + int'($urandom % 3), 0, 1'b1, c, tag);
    step = model_next(step, c);
  endtask

  task automatic long_gap();
    repeat (GAP * 2 + 20) @(negedge clk);
    step = 0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(wr_valid == 1'b0 && wr_class == 2'd0 && wr_addr == 13'd0, "R1 reset outputs",
          {wr_valid, wr_class}, 0);
    @(negedge clk) rst = 1'b0;
    // R4: no power yet
    do_write(13'h0100, 8'h11, MINP, 0, 1'b0, 2'd0, "R4 supply low");
    pwr_ok = 1'b1;
    do_write(13'h0100, 8'h12, MINP, 0, 1'b0, 2'd0, "R4 inside hold");
    repeat (PDLY + 5) @(negedge clk);
    step = 0;
    // R8: unprotected write
    wr(13'h0123, 8'h5A, "R8 no unlock");
    // R3: glitch boundary
    do_write(13'h0200, 8'h33, MINP - 1, 0, 1'b0, 2'd0, "R3 short pulse");
    do_write(13'h0201, 8'h34, MINP, 0, 1'b1, 2'd3, "R3 exact width");
    // R2: inhibits
    do_write(13'h0202, 8'h35, MINP + 2, 1, 1'b0, 2'd0, "R2 oe low");
    do_write(13'h0203, 8'h36, MINP + 2, 2, 1'b0, 2'd0, "R2 ce high");
    // R9: capture points
    do_write(13'h0404, 8'hC3, MINP + 2, 3, 1'b1, 2'd3, "R9 capture edges");
    // R5 / R6: full unlock then page payload
    for (int i = 0; i < 3; i++) wr(cmd_a(i), cmd_d(i), "R5 unlock");
    wr(13'h1555, 8'hAA, "R6 payload looks like cmd");
    wr(13'h0040, 8'h01, "R6 payload");
    wr(13'h0041, 8'h02, "R6 payload");
    // R7: timeout closes load
    long_gap();
    wr(13'h0042, 8'h03, "R7 after load timeout");
    // R8: mismatch partway
    wr(cmd_a(0), cmd_d(0), "R8 step0");
    wr(13'h0AAA, 8'h56, "R8 bad data");
    wr(cmd_a(1), cmd_d(1), "R8 step1 after reset");
    // R7: partial unlock expires
    wr(cmd_a(0), cmd_d(0), "R7 step0");
    wr(cmd_a(1), cmd_d(1), "R7 step1");
    long_gap();
    wr(cmd_a(2), cmd_d(2), "R7 step2 late");
    // R4: supply dip restarts hold
    @(negedge clk) pwr_ok = 1'b0;
    @(negedge clk) pwr_ok = 1'b1;
    do_write(13'h0500, 8'h77, MINP, 0, 1'b0, 2'd0, "R4 after dip");
    repeat (PDLY + 5) @(negedge clk);
    step = 0;
    // random mix against the model
    for (int it = 0; it < 200; it++) begin
      int r = int'($urandom % 10);
      if (r < 4) begin
        if (step < 3) wr(cmd_a(step), cmd_d(step), "R5 random unlock");
        else wr(13'($urandom), 8'($urandom), "R6 random store");
      end else if (r == 6) begin
        do_write(13'($urandom), 8'($urandom), 1 + int'($urandom % (MINP - 1)), 0,
                 1'b0, 2'd0, "R3 random glitch");
      end else if (r == 7) begin
        long_gap();
      end else begin
        wr(13'($urandom), 8'($urandom), "R8 random write");
      end
      repeat (int'($urandom % 6)) @(negedge clk);
    end
    finish_run();
  end
endmodule